// File: doc/BRIEF.md
# Serial Control Register Port

This block is the write-only serial control port of a small mixed-signal front end. A host drives three pins: a serial clock, an active-low select and a data line. The block assembles one 16-bit write frame from them and keeps it in a bank of four 8-bit control registers. The block's fast system clock samples the pins through synchronisers, so a frame is assembled by edge detection inside that clock domain. The registers drive the rest of the chip directly: input routing, power enables, mode fields and input gain.

A frame is committed only when the host releases the select line. All four of these conditions must hold: exactly sixteen serial clock rising edges arrived while the select was low, the leading device code matches, the write flag is set, and the register index names one of the four registers. Register 01h holds the power enables, and writes to it are refused while the front end reports that it is still initialising. A synchronous active-low reset puts every register back to its power-on value.

Top module: `ctrl_serial_regs`

## Requirements
- R1: A frame is sent MSB first and is sampled on rising edges of `ser_clk`. Its bits 15:14 are the device code, bit 13 is the write flag, bits 12:8 are the register index and bits 7:0 are the data.
- R2: A frame changes no register while `ser_cs_n` stays low. Its data appears on the register outputs only after `ser_cs_n` rises.
- R3: A frame whose device code is not binary 10, or whose write flag is 0, leaves every register unchanged.
- R4: A frame that had any count of `ser_clk` rising edges other than 16 between the fall and the rise of `ser_cs_n` leaves every register unchanged, even when its last 16 bits form a valid frame.
- R5: While `rst_n` is low at a `clk` edge, the registers take index 00h = 0x45, 01h = 0x03, 02h = 0x30 and 03h = 0x28.
- R6: Frames with register index 04h through 1Fh change no register. In particular, the low two index bits never alias onto registers 00h to 03h.
- R7: While `init_busy` is high, a frame to index 01h leaves `reg_power` unchanged. Frames to the other indices still take effect.
- R8: Unused bits always read 0, whatever data is written. These are bit 7 of index 00h, bits 7:2 of index 01h (bit 0 is mic power, bit 1 is converter power), and bits 3:2 and bit 0 of index 02h (bits 7:6 mono mode, bits 5:4 timeout select, bit 1 format select). All bits of index 03h are kept.
- R9: Between accepted frames and outside reset, every register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset / power-down |
| init_busy | input | 1 | High while the front end initialises; blocks writes to index 01h |
| ser_clk | input | 1 | Serial clock from the host |
| ser_cs_n | input | 1 | Active-low frame select from the host |
| ser_din | input | 1 | Serial data from the host |
| reg_in_sel | output | 8 | Register 00h: input routing, filter bypass, preamp gain |
| reg_power | output | 8 | Register 01h: power enables |
| reg_mode | output | 8 | Register 02h: mono mode, timeout, format |
| reg_gain | output | 8 | Register 03h: gain code and zero-cross enable |

## Verification
Any fault in this block becomes visible on one of the four register outputs within a few system clocks of the select line rising. A miscounted bit counter accepts a short or long frame. A shift fault lands data at the wrong index or in the wrong bits. A commit taken at the wrong time shows new data while the select is still low. A mask or inhibit fault leaves a nonzero unused bit or a changed power register. For this reason the bench compares all four outputs against its own register model after every frame, and also in the middle of selected frames.

// File: rtl/ctrl_serial_regs_pkg.sv
// Package: shared sizes, device code, register defaults and write masks
// for the serial control register port.
package ctrl_serial_regs_pkg;

    localparam int FRAME_BITS = 16;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 8;
    localparam int NUM_REGS   = 4;
    localparam int CODE_W     = 2;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);

    localparam logic [CODE_W-1:0] DEVICE_CODE = 2'b10;
    localparam int                IDX_POWER   = 1;

    typedef logic [DATA_W-1:0] cbyte_t;
    typedef logic [NUM_REGS-1:0][DATA_W-1:0] regfile_t;

    // Power-on value of register i
    function automatic cbyte_t reg_default(input int i);
        case (i)
            0:       return 8'h45;
            1:       return 8'h03;
            2:       return 8'h30;
            3:       return 8'h28;
            default: return 8'h00;
        endcase
    endfunction

    // Writable bits of register i; the rest always read 0
    function automatic cbyte_t reg_mask(input int i);
        case (i)
            0:       return 8'h7F;
            1:       return 8'h03;
            2:       return 8'hF2;
            3:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    // All defaults packed into one register file value
    function automatic regfile_t all_defaults();
        regfile_t r;
        for (int i = 0; i < NUM_REGS; i++) r[i] = reg_default(i);
        return r;
    endfunction

endpackage

// File: rtl/ctrl_pin_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous pins.
// Assumes: each bit is independent; on reset every stage takes the
// idle value given by IDLE_VAL so no false edge appears after reset.
module ctrl_pin_sync #(
    parameter int              WIDTH    = 3,
    parameter int              STAGES   = 2,
    parameter logic [WIDTH-1:0] IDLE_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_sync
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        // Shift the pin through the synchroniser chain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= {STAGES{IDLE_VAL[b]}};
            end else if (STAGES == 1) begin
                chain_q <= pin_in[b];
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pin_in[b]};
            end
        end

        assign pin_sync[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/ctrl_frame_shift.sv
// Module: serial frame receiver. It detects serial clock rising edges
// and select rising edges in the system clock domain, counts bits and
// shifts them in MSB first. On select release it issues a one-cycle
// write strobe when the frame is well formed.
// Assumes: synchronised inputs; the host keeps each serial level for
// several system clocks and keeps the select high for more than one.
module ctrl_frame_shift
    import ctrl_serial_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              din_s,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output cbyte_t            wr_data
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);
    localparam int               RW_BIT   = FRAME_BITS - CODE_W - 1;

    logic                  sclk_prev, csn_prev;
    logic                  sclk_rise, csn_rise;
    logic [CNT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] shreg;
    logic                  frame_ok;

    // Remember the previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            csn_prev  <= 1'b1;
        end else begin
            sclk_prev <= sclk_s;
            csn_prev  <= csn_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_prev;
    assign csn_rise  = csn_s & ~csn_prev;

    // Shift data and count clock edges while selected; clear while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (csn_s) begin
            bit_cnt <= '0;
        end else if (sclk_rise) begin
            shreg <= {shreg[FRAME_BITS-2:0], din_s};
            if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign frame_ok = (bit_cnt == CNT_FULL)
                   && (shreg[FRAME_BITS-1 -: CODE_W] == DEVICE_CODE)
                   && shreg[RW_BIT];

    // Register the write request on select release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb  <= csn_rise && frame_ok;
            wr_addr <= shreg[RW_BIT-1 -: ADDR_W];
            wr_data <= shreg[DATA_W-1:0];
        end
    end

    // A commit is a single pulse per select release (R2)
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // Bit counter never passes its overflow marker (R4)
    p_count_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt == CNT_OVER && !csn_s) |=> (bit_cnt == CNT_OVER || csn_prev));

endmodule

// File: rtl/ctrl_reg_bank.sv
// Module: four masked control registers. A strobe writes the indexed
// register; indices beyond the bank are dropped; the power register
// refuses writes while the front end initialises.
// Assumes: init_busy is synchronous to clk.
module ctrl_reg_bank
    import ctrl_serial_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_busy,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  cbyte_t            wr_data,
    output regfile_t          regs_q
);

    localparam regfile_t DEFAULTS = all_defaults();

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam cbyte_t MASK     = reg_mask(i);
        localparam cbyte_t DEF      = reg_default(i);
        localparam bit     GUARDED  = (i == IDX_POWER);
        logic hit;

        assign hit = wr_stb && (wr_addr == ADDR_W'(i)) && !(GUARDED && init_busy);

        // Load default on reset, masked data on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[i] <= DEF;
            end else if (hit) begin
                regs_q[i] <= wr_data & MASK;
            end
        end
    end

    // Reset loads the defaults (R5)
    p_reset_defaults_r5: assert property (@(posedge clk)
        !rst_n |=> (regs_q == DEFAULTS));

    // No strobe, no change (R9)
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(regs_q));

    // Indices past the bank are dropped (R6)
    p_high_index_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr >= ADDR_W'(NUM_REGS)) |=> $stable(regs_q));

    // Power register frozen while initialising (R7)
    p_power_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && init_busy) |=> $stable(regs_q[IDX_POWER]));

endmodule

// File: rtl/ctrl_serial_regs.sv
// Module: top of the serial control register port. Synchronises the
// three host pins, receives frames and holds the control registers.
// Assumes: clk is several times faster than the serial clock.
module ctrl_serial_regs
    import ctrl_serial_regs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_busy,
    input  logic       ser_clk,
    input  logic       ser_cs_n,
    input  logic       ser_din,
    output logic [7:0] reg_in_sel,
    output logic [7:0] reg_power,
    output logic [7:0] reg_mode,
    output logic [7:0] reg_gain
);

    logic [2:0]        pins_s;
    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    cbyte_t            wr_data;
    regfile_t          regs_q;

    ctrl_pin_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .IDLE_VAL(3'b010)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  ({ser_din, ser_cs_n, ser_clk}),
        .pin_sync(pins_s)
    );

    ctrl_frame_shift u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (pins_s[0]),
        .csn_s  (pins_s[1]),
        .din_s  (pins_s[2]),
        .wr_stb (wr_stb),
        .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    ctrl_reg_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_busy(init_busy),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .regs_q   (regs_q)
    );

    assign reg_in_sel = regs_q[0];
    assign reg_power  = regs_q[1];
    assign reg_mode   = regs_q[2];
    assign reg_gain   = regs_q[3];

    // Unused bits never set on the outputs (R8)
    p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_in_sel[7] == 1'b0) && (reg_power[7:2] == 6'd0)
        && (reg_mode[3:2] == 2'd0) && (reg_mode[0] == 1'b0));

endmodule

// File: tb/test_ctrl_serial_regs.sv
// Bench: directed corner frames plus seeded random frames, checked
// against a register model kept in the bench.
module test_ctrl_serial_regs;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_busy = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_cs_n = 1'b1;
    logic ser_din = 1'b0;
    logic [7:0] reg_in_sel, reg_power, reg_mode, reg_gain;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [7:0] model [4];

    always #2.5 clk = ~clk;

    ctrl_serial_regs i_ctrl_serial_regs (
        .clk(clk), .rst_n(rst_n), .init_busy(init_busy),
        .ser_clk(ser_clk), .ser_cs_n(ser_cs_n), .ser_din(ser_din),
        .reg_in_sel(reg_in_sel), .reg_power(reg_power),
        .reg_mode(reg_mode), .reg_gain(reg_gain)
    );

    function automatic logic [7:0] def_of(input int i);
        case (i) 0: return 8'h45; 1: return 8'h03; 2: return 8'h30; default: return 8'h28; endcase
    endfunction

    function automatic logic [7:0] mask_of(input int i);
        case (i) 0: return 8'h7F; 1: return 8'h03; 2: return 8'hF2; default: return 8'hFF; endcase
    endfunction

    function automatic logic [15:0] mk(input logic [1:0] code, input logic rw,
                                       input logic [4:0] idx, input logic [7:0] d);
        return {code, rw, idx, d};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_all(input string req);
        logic [7:0] got [4];
        @(negedge clk);
        got[0] = reg_in_sel; got[1] = reg_power; got[2] = reg_mode; got[3] = reg_gain;
        for (int i = 0; i < 4; i++) begin
            total++;
            if (got[i] !== model[i]) begin
                bad++;
                $display("FAIL %s reg%0d actual=%02h expected=%02h", req, i, got[i], model[i]);
            end
        end
    endtask

    // Send n bits of v MSB first; optionally check mid-frame (R2)
    task automatic send(input logic [23:0] v, input int n, input bit mid, input string req);
        ser_cs_n = 1'b0;
        wait_clk(6);
        for (int b = n - 1; b >= 0; b--) begin
            ser_din = v[b];
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
        wait_clk(8);
        if (mid) check_all("R2 mid-frame");
        ser_cs_n = 1'b1;
        // Model update: exactly 16 bits, code 10, write flag, valid index
        if (n == 16 && v[15:14] == 2'b10 && v[13] && v[12:8] < 5'd4
            && !(v[12:8] == 5'd1 && init_busy))
            model[v[9:8]] = v[7:0] & mask_of(int'(v[9:8]));
        wait_clk(10);
        check_all(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) model[i] = def_of(i);
        wait_clk(2);
    endtask

    initial begin
        int unused_seed;
        logic [23:0] v;
        int n;
        unused_seed = $urandom(32'd7411);
        for (int i = 0; i < 4; i++) model[i] = def_of(i);
        wait_clk(4);
        check_all("R5 reset defaults");
        rst_n = 1'b1;
        wait_clk(4);
        check_all("R5 after release");

        send({8'h0, mk(2'b10, 1'b1, 5'd0, 8'hFF)}, 16, 1'b1, "R1 R8 reg00");
        send({8'h0, mk(2'b10, 1'b1, 5'd2, 8'hFF)}, 16, 1'b1, "R8 reg02");
        send({8'h0, mk(2'b10, 1'b1, 5'd1, 8'hFE)}, 16, 1'b0, "R8 reg01");
        send({8'h0, mk(2'b10, 1'b1, 5'd3, 8'hA6)}, 16, 1'b1, "R1 reg03");
        send({8'h0, mk(2'b01, 1'b1, 5'd3, 8'h11)}, 16, 1'b0, "R3 bad code");
        send({8'h0, mk(2'b10, 1'b0, 5'd3, 8'h22)}, 16, 1'b0, "R3 read flag");
        send({8'h0, mk(2'b10, 1'b1, 5'd3, 8'h33)} >> 1, 15, 1'b0, "R4 short frame");
        send({7'h0, 1'b1, mk(2'b10, 1'b1, 5'd3, 8'h44)}, 17, 1'b0, "R4 long frame");
        send({8'h0, mk(2'b10, 1'b1, 5'd4, 8'h01)}, 16, 1'b0, "R6 index 04h");
        send({8'h0, mk(2'b10, 1'b1, 5'd31, 8'h02)}, 16, 1'b0, "R6 index 1Fh");
        init_busy = 1'b1;
        send({8'h0, mk(2'b10, 1'b1, 5'd1, 8'h03)}, 16, 1'b0, "R7 power blocked");
        send({8'h0, mk(2'b10, 1'b1, 5'd2, 8'h40)}, 16, 1'b0, "R7 others written");
        init_busy = 1'b0;
        send({8'h0, mk(2'b10, 1'b1, 5'd1, 8'h02)}, 16, 1'b0, "R7 power after init");
        wait_clk(30);
        check_all("R9 hold");
        do_reset();
        check_all("R5 reset mid-run");

        for (int k = 0; k < 60; k++) begin
            logic [1:0] code;
            code = ($urandom % 4 == 0) ? 2'($urandom) : 2'b10;
            n = ($urandom % 6 == 0) ? (15 + 2 * ($urandom % 2)) : 16;
            init_busy = ($urandom % 4 == 0);
            v = {8'($urandom), mk(code, ($urandom % 8 != 0), 5'($urandom % 7), 8'($urandom))};
            if (n == 15) v = v >> 1;
            send(v, n, ($urandom % 5 == 0), "R1 R3 R4 R6 R7 random");
        end
        init_busy = 1'b0;

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule